// File: doc/BRIEF.md
# Word-Load Execution Engine

This block is a small multi-cycle executor for the 16-bit data-movement subset of an 8-bit processor core. It fetches an opcode and any operand bytes over a byte-wide synchronous memory port. It holds five 16-bit register pairs: BC, DE, HL, AF and the stack pointer SP. It executes five instruction kinds:

- load a pair with an immediate word
- load HL from a direct address
- store HL to a direct address
- push a pair onto a stack that grows downwards
- pop a pair from that stack

All words move one byte at a time, low byte at the lower address. One clock is one T-state. Every instruction runs through machine cycles of fixed length, and `done` pulses on its final T-state.

Any other opcode is treated as illegal. It takes a single 4-T fetch cycle and raises `illegal` together with `done`. The program counter moves past the opcode and nothing else changes. The memory port has a one-cycle read latency. The byte at the address presented with `mem_re` appears on `mem_rdata` in the following clock.

Top module: `wl_exec`

## Requirements
- R1: While reset is held, BC, DE, HL and AF read 0000h, SP reads the reset value (0000h by default), no write is issued and `done` is low. The first cycle after release fetches the opcode at the reset PC (0000h by default).
- R2: An opcode whose bit pattern is 00pp0001 loads a pair with the word {second byte, first byte} that follows the opcode. The field pp encodes 00=BC, 01=DE, 10=HL and 11=SP. The instruction takes 10 T-states as machine cycles of 4+3+3, and the PC advances by 3.
- R3: Opcode 2Ah reads an address nn from the next two bytes, low byte first. It then loads HL with {byte at nn+1, byte at nn} over 16 T-states as 4+3+3+3+3.
- R4: Opcode 22h writes L to nn in the fourth machine cycle and H to nn+1 in the fifth. It also takes 16 T-states.
- R5: An opcode 11qq0101 pushes a pair, with qq encoding 00=BC, 01=DE, 10=HL and 11=AF. It writes the high byte at SP-1 first, then the low byte at SP-2, and SP ends at SP-2. It takes 11 T-states as 5+3+3.
- R6: An opcode 11qq0001 pops a pair, with qq encoded as in R5. It reads the low byte at SP, then the high byte at SP+1, and SP ends at SP+2. It takes 10 T-states as 4+3+3.
- R7: The address calculations nn+1, SP-1, SP-2, SP+1 and SP+2 wrap modulo 65536.
- R8: `done` is high for exactly one T-state per instruction: the last one. Two consecutive cycles never both carry `done`.
- R9: Any other opcode pulses `illegal` and `done` on the 4th T-state of its fetch. The PC advances by one, and no pair or memory byte changes.
- R10: No instruction alters AF except a pop with qq=11.
- R11: A memory access occurs only in the first T-state of a machine cycle, and `mem_re` and `mem_we` are never high together.
- R12: Register pairs change only at the clock edge that ends an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 8 | Read byte, valid one cycle after `mem_re` |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| done | output | 1 | Last T-state of an instruction |
| illegal | output | 1 | Unsupported opcode, high with `done` |
| bc | output | 16 | BC pair |
| de | output | 16 | DE pair |
| hl | output | 16 | HL pair |
| af | output | 16 | AF pair |
| sp | output | 16 | Stack pointer |

## Verification
The assertions assume that the memory behind the port answers every read with a defined byte in the next clock. They also assume that reset is released only while the sequencer is parked at the start of a fetch.

The bench meets the first assumption with a memory model that returns zero for any byte never written. It meets the second by releasing reset on a falling edge after several held cycles.

The program mixes every opcode form and every pair code. It includes illegal opcodes next to legal ones, and accesses that wrap through address FFFFh. Because of this, each stack and direct-address ordering is reached with a known stack pointer.

// File: rtl/wl_pkg.sv
package wl_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        K_LDI,
        K_LDHL,
        K_STHL,
        K_PUSH,
        K_POP,
        K_ILL
    } kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] wz;
        logic [WORD_W-1:0] bc;
        logic [WORD_W-1:0] de;
        logic [WORD_W-1:0] hl;
        logic [WORD_W-1:0] af;
        logic [WORD_W-1:0] sp;
        logic [BYTE_W-1:0] ir;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } core_t;
endpackage

// File: rtl/wl_decode.sv
module wl_decode
    import wl_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output kind_e             kind,
    output logic [1:0]        sel
);
    always_comb begin
        sel = op[5:4];
        if ((op & 8'hCF) == 8'h01)      kind = K_LDI;
        else if (op == 8'h2A)           kind = K_LDHL;
        else if (op == 8'h22)           kind = K_STHL;
        else if ((op & 8'hCF) == 8'hC5) kind = K_PUSH;
        else if ((op & 8'hCF) == 8'hC1) kind = K_POP;
        else                            kind = K_ILL;
    end
endmodule

// File: rtl/wl_tseq.sv
module wl_tseq
    import wl_pkg::*;
#(
    parameter int FETCH_T      = 4,
    parameter int FETCH_LONG_T = 5,
    parameter int MEM_T        = 3,
    localparam int TW          = $clog2(FETCH_LONG_T)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  kind_e         kind,
    output logic [2:0]    mcyc,
    output logic [TW-1:0] tst,
    output logic          fin
);
    typedef struct packed {
        logic [2:0]    m;
        logic [TW-1:0] t;
    } seq_t;

    seq_t s_q, s_d;
    logic [TW-1:0] last_t;
    logic [2:0]    last_m;

    always_comb begin
        if (s_q.m == 3'd0)
            last_t = (kind == K_PUSH) ? TW'(FETCH_LONG_T - 1) : TW'(FETCH_T - 1);
        else
            last_t = TW'(MEM_T - 1);
        case (kind)
            K_LDHL, K_STHL: last_m = 3'd4;
            K_ILL:          last_m = 3'd0;
            default:        last_m = 3'd2;
        endcase
        fin = (s_q.t == last_t) && (s_q.m == last_m);
        s_d = s_q;
        if (s_q.t == last_t) begin
            s_d.t = '0;
            s_d.m = fin ? 3'd0 : s_q.m + 3'd1;
        end else begin
            s_d.t = s_q.t + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mcyc = s_q.m;
    assign tst  = s_q.t;

    p_tstate_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.t) < FETCH_LONG_T);
    p_mcyc_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.m <= 3'd4);
endmodule

// File: rtl/wl_exec.sv
module wl_exec
    import wl_pkg::*;
#(
    parameter logic [15:0] RESET_PC     = 16'h0000,
    parameter logic [15:0] RESET_SP     = 16'h0000,
    parameter int          FETCH_T      = 4,
    parameter int          FETCH_LONG_T = 5,
    parameter int          MEM_T        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic              mem_we,
    output logic              done,
    output logic              illegal,
    output logic [WORD_W-1:0] bc,
    output logic [WORD_W-1:0] de,
    output logic [WORD_W-1:0] hl,
    output logic [WORD_W-1:0] af,
    output logic [WORD_W-1:0] sp
);
    localparam int TW = $clog2(FETCH_LONG_T);

    core_t         cur_q, nx_d;
    kind_e         kind;
    logic [1:0]    sel;
    logic [2:0]    mcyc;
    logic [TW-1:0] tst;
    logic          fin, acc, cap;
    logic [WORD_W-1:0] stk_src;

    wl_decode u_dec (.op(cur_q.ir), .kind(kind), .sel(sel));

    wl_tseq #(
        .FETCH_T(FETCH_T), .FETCH_LONG_T(FETCH_LONG_T), .MEM_T(MEM_T)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .kind(kind),
        .mcyc(mcyc), .tst(tst), .fin(fin)
    );

    always_comb begin
        case (sel)
            2'd0:    stk_src = cur_q.bc;
            2'd1:    stk_src = cur_q.de;
            2'd2:    stk_src = cur_q.hl;
            default: stk_src = cur_q.af;
        endcase
    end

    always_comb begin
        nx_d      = cur_q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q.pc;
        mem_wdata = '0;
        acc       = (tst == '0);
        cap       = (tst == TW'(1));
        if (mcyc == 3'd0) begin
            mem_re = acc;
            if (cap) begin
                nx_d.ir = mem_rdata;
                nx_d.pc = cur_q.pc + 16'd1;
            end
        end else begin
            case (kind)
                K_LDI: begin
                    mem_re = acc;
                    if (cap) begin
                        nx_d.pc = cur_q.pc + 16'd1;
                        if (mcyc == 3'd1) nx_d.lo = mem_rdata;
                        else              nx_d.hi = mem_rdata;
                    end
                end
                K_LDHL, K_STHL: begin
                    if (mcyc <= 3'd2) begin
                        mem_re = acc;
                        if (cap) begin
                            nx_d.pc = cur_q.pc + 16'd1;
                            if (mcyc == 3'd1) nx_d.wz[7:0]  = mem_rdata;
                            else              nx_d.wz[15:8] = mem_rdata;
                        end
                    end else begin
                        mem_addr  = (mcyc == 3'd3) ? cur_q.wz : cur_q.wz + 16'd1;
                        mem_wdata = (mcyc == 3'd3) ? cur_q.hl[7:0] : cur_q.hl[15:8];
                        if (kind == K_LDHL) begin
                            mem_re = acc;
                            if (cap) begin
                                if (mcyc == 3'd3) nx_d.lo = mem_rdata;
                                else              nx_d.hi = mem_rdata;
                            end
                        end else begin
                            mem_we = acc;
                        end
                    end
                end
                K_PUSH: begin
                    mem_we    = acc;
                    mem_addr  = cur_q.sp - ((mcyc == 3'd1) ? 16'd1 : 16'd2);
                    mem_wdata = (mcyc == 3'd1) ? stk_src[15:8] : stk_src[7:0];
                end
                K_POP: begin
                    mem_re   = acc;
                    mem_addr = (mcyc == 3'd1) ? cur_q.sp : cur_q.sp + 16'd1;
                    if (cap) begin
                        if (mcyc == 3'd1) nx_d.lo = mem_rdata;
                        else              nx_d.hi = mem_rdata;
                    end
                end
                default: ;
            endcase
        end
        if (fin) begin
            case (kind)
                K_LDI: begin
                    case (sel)
                        2'd0:    nx_d.bc = {nx_d.hi, cur_q.lo};
                        2'd1:    nx_d.de = {nx_d.hi, cur_q.lo};
                        2'd2:    nx_d.hl = {nx_d.hi, cur_q.lo};
                        default: nx_d.sp = {nx_d.hi, cur_q.lo};
                    endcase
                end
                K_LDHL: nx_d.hl = {cur_q.hi, cur_q.lo};
                K_PUSH: nx_d.sp = cur_q.sp - 16'd2;
                K_POP: begin
                    nx_d.sp = cur_q.sp + 16'd2;
                    case (sel)
                        2'd0:    nx_d.bc = {cur_q.hi, cur_q.lo};
                        2'd1:    nx_d.de = {cur_q.hi, cur_q.lo};
                        2'd2:    nx_d.hl = {cur_q.hi, cur_q.lo};
                        default: nx_d.af = {cur_q.hi, cur_q.lo};
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.pc <= RESET_PC;
            cur_q.sp <= RESET_SP;
        end else begin
            cur_q <= nx_d;
        end
    end

    assign done    = fin;
    assign illegal = fin && (kind == K_ILL);
    assign bc = cur_q.bc;
    assign de = cur_q.de;
    assign hl = cur_q.hl;
    assign af = cur_q.af;
    assign sp = cur_q.sp;

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    p_access_first_t_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> (tst == '0));
    p_illegal_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);
    p_done_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_pairs_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable({bc, de, hl, af, sp}));
    p_af_pop_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(kind == K_POP && sel == 2'd3)) |=> $stable(af));
    p_push_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind == K_PUSH) |=> (sp == $past(sp) - 16'd2));
    p_pop_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind == K_POP) |=> (sp == $past(sp) + 16'd2));
endmodule

// File: tb/test_wl_exec.sv
`timescale 1ns/1ps
module test_wl_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_re, mem_we, done, illegal;
    logic [15:0] bc, de, hl, af, sp;

    always #2 clk = ~clk;

    wl_exec i_wl_exec (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_we(mem_we), .done(done), .illegal(illegal),
        .bc(bc), .de(de), .hl(hl), .af(af), .sp(sp)
    );

    logic [7:0] mem [int];

    function automatic logic [7:0] rd(logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    always @(posedge clk) begin
        mem_rdata <= rd(mem_addr);
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    localparam int PLEN = 57;
    localparam logic [7:0] PROG [PLEN] = '{
        8'h31, 8'h07, 8'h10, 8'hF1, 8'h31, 8'h07, 8'h10, 8'hF5,
        8'h01, 8'h34, 8'h12, 8'h11, 8'h78, 8'h56, 8'h21, 8'h3A,
        8'h48, 8'h22, 8'h29, 8'hB2, 8'h21, 8'h00, 8'h00, 8'h2A,
        8'h29, 8'hB2, 8'h31, 8'h00, 8'h10, 8'hE1, 8'hC5, 8'hD5,
        8'hE5, 8'hC1, 8'hD1, 8'h76, 8'h00, 8'h31, 8'h00, 8'h00,
        8'hE5, 8'h31, 8'hFF, 8'hFF, 8'hD1, 8'h22, 8'hFF, 8'hFF,
        8'h2A, 8'hFF, 8'hFF, 8'h31, 8'h00, 8'h20, 8'hCB, 8'h32,
        8'hED
    };

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic re, we;
        logic [15:0] a;
        logic [7:0] d;
        logic dn, il;
    } cyc_t;

    cyc_t q[$];
    logic [15:0] rr [5];     // 0 BC, 1 DE, 2 HL, 3 AF, 4 SP
    logic [15:0] post [5];
    logic [15:0] rpc, post_pc;
    string cur_req;

    task automatic mcyc(int n, logic re, logic we, logic [15:0] a, logic [7:0] d);
        q.push_back({re, we, a, d, 1'b0, 1'b0});
        for (int i = 1; i < n; i++) q.push_back({1'b0, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0});
    endtask

    task automatic gen();
        logic [7:0]  op;
        logic [15:0] nn, s;
        int idx;
        cyc_t last;
        op = rd(rpc);
        for (int i = 0; i < 5; i++) post[i] = rr[i];
        s = rr[4];
        if ((op & 8'hCF) == 8'h01) begin
            cur_req = "R2";
            idx = (op[5:4] == 2'd3) ? 4 : int'(op[5:4]);
            mcyc(4, 1, 0, rpc, 0);
            mcyc(3, 1, 0, rpc + 16'd1, 0);
            mcyc(3, 1, 0, rpc + 16'd2, 0);
            post[idx] = {rd(rpc + 16'd2), rd(rpc + 16'd1)};
            post_pc = rpc + 16'd3;
        end else if (op == 8'h2A || op == 8'h22) begin
            nn = {rd(rpc + 16'd2), rd(rpc + 16'd1)};
            cur_req = (nn == 16'hFFFF) ? "R7" : ((op == 8'h2A) ? "R3" : "R4");
            mcyc(4, 1, 0, rpc, 0);
            mcyc(3, 1, 0, rpc + 16'd1, 0);
            mcyc(3, 1, 0, rpc + 16'd2, 0);
            if (op == 8'h2A) begin
                mcyc(3, 1, 0, nn, 0);
                mcyc(3, 1, 0, nn + 16'd1, 0);
                post[2] = {rd(nn + 16'd1), rd(nn)};
            end else begin
                mcyc(3, 0, 1, nn, rr[2][7:0]);
                mcyc(3, 0, 1, nn + 16'd1, rr[2][15:8]);
            end
            post_pc = rpc + 16'd3;
        end else if ((op & 8'hCF) == 8'hC5) begin
            cur_req = (s < 16'd2) ? "R7" : "R5";
            idx = int'(op[5:4]);
            mcyc(5, 1, 0, rpc, 0);
            mcyc(3, 0, 1, s - 16'd1, rr[idx][15:8]);
            mcyc(3, 0, 1, s - 16'd2, rr[idx][7:0]);
            post[4] = s - 16'd2;
            post_pc = rpc + 16'd1;
        end else if ((op & 8'hCF) == 8'hC1) begin
            cur_req = (s >= 16'hFFFE) ? "R7" : "R6";
            idx = int'(op[5:4]);
            mcyc(4, 1, 0, rpc, 0);
            mcyc(3, 1, 0, s, 0);
            mcyc(3, 1, 0, s + 16'd1, 0);
            post[idx] = {rd(s + 16'd1), rd(s)};
            post[4] = s + 16'd2;
            post_pc = rpc + 16'd1;
        end else begin
            cur_req = "R9";
            mcyc(4, 1, 0, rpc, 0);
            post_pc = rpc + 16'd1;
        end
        last = q[q.size() - 1];
        last.dn = 1'b1;
        last.il = (cur_req == "R9");
        q[q.size() - 1] = last;
    endtask

    task automatic check_cycle();
        cyc_t e;
        bit ok;
        if (q.size() == 0) gen();
        e = q.pop_front();
        chk(!(mem_re && mem_we), "R11", "strobes", {mem_re, mem_we}, 2'b00);
        ok = (mem_re == e.re) && (mem_we == e.we) &&
             ((!e.re && !e.we) || mem_addr == e.a) &&
             (!e.we || mem_wdata == e.d) && (illegal == e.il);
        chk(ok, cur_req, "bus", {mem_re, mem_we, mem_addr, illegal},
            {e.re, e.we, e.a, e.il});
        chk(done == e.dn, "R8", "done", done, e.dn);
        chk(bc == rr[0], "R12", "bc", bc, rr[0]);
        chk(de == rr[1], "R12", "de", de, rr[1]);
        chk(hl == rr[2], "R12", "hl", hl, rr[2]);
        chk(af == rr[3], "R10", "af", af, rr[3]);
        chk(sp == rr[4], "R12", "sp", sp, rr[4]);
        if (e.dn) begin
            for (int i = 0; i < 5; i++) rr[i] = post[i];
            rpc = post_pc;
        end
    endtask

    initial begin
        int idle;
        for (int i = 0; i < PLEN; i++) mem[i] = PROG[i];
        mem[32'h1007] = 8'h33;
        mem[32'h1008] = 8'h22;
        mem[32'h1000] = 8'h55;
        mem[32'h1001] = 8'h33;
        for (int i = 0; i < 5; i++) rr[i] = 16'h0000;
        rpc = 16'h0000;
        repeat (4) @(negedge clk);
        chk(bc == 0 && de == 0 && hl == 0 && af == 0, "R1", "pairs in reset",
            {bc, de}, 32'h0);
        chk(sp == 16'h0000, "R1", "sp in reset", sp, 16'h0000);
        chk(!done && !mem_we, "R1", "idle in reset", {done, mem_we}, 2'b00);
        rst_n = 1'b1;
        chk(mem_re && mem_addr == 16'h0000, "R1", "first fetch", {mem_re, mem_addr},
            {1'b1, 16'h0000});
        idle = 0;
        for (int c = 0; c < 900; c++) begin
            check_cycle();
            idle = done ? 0 : idle + 1;
            if (idle > 20) begin
                chk(1'b0, "R8", "watchdog", idle, 20);
                break;
            end
            @(negedge clk);
        end
        chk(rd(16'h1006) == 8'h22, "R5", "push high byte", rd(16'h1006), 8'h22);
        chk(rd(16'h1005) == 8'h33, "R5", "push low byte", rd(16'h1005), 8'h33);
        chk(rd(16'hB229) == 8'h3A, "R4", "store low", rd(16'hB229), 8'h3A);
        chk(rd(16'hB22A) == 8'h48, "R4", "store high", rd(16'hB22A), 8'h48);
        chk(rd(16'hFFFF) == 8'h55, "R7", "wrapped store low", rd(16'hFFFF), 8'h55);
        chk(rd(16'h0000) == 8'h33, "R7", "wrapped store high", rd(16'h0000), 8'h33);
        chk(af == 16'h2233, "R6", "pop AF result", af, 16'h2233);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule